// File: doc/BRIEF.md
# Chip-Enable-Latched Parallel Byte Memory

This block is a byte-wide memory with a pin-level parallel interface: an address bus, a data bus split into input, output and output-enable, and three active-low strobes (chip enable, output enable, write enable). A fast system clock samples the strobes through two-flop synchronisers. The falling edge of the synchronised chip enable captures the address. Every read and write in that access then uses the captured address and ignores the live address pins until chip enable goes high again. That rising edge opens a precharge window, and the block ignores any new access until the window has expired.

The data bus is a plain pin-level bus, so it has no valid/ready handshake and no back-pressure. The host holds the address and data stable around the strobe edges, and it may only rely on read data while the output-enable pin is high. The storage holds `2**ADDR_W` bytes. `ADDR_W = 13` gives the full 8,192-byte array, and the default build uses a smaller array. Reset clears only the control state and leaves the stored bytes untouched.

Top module: `cel_byte_mem`

## Requirements
- R1: After the active-high synchronous reset, `dout_oe` is 0.
- R2: In a read access (chip enable low, write enable high, output enable low), `dout` shows the byte stored at the captured address and `dout_oe` is 1.
- R3: Once an access has captured its address, later changes on `addr_i` do not change which location is read or written until the next accepted chip-enable fall.
- R4: While an access is active and write enable is low, `din` is stored at the captured address. The location named by the live `addr_i` pins is not written.
- R5: If write enable is already low when chip enable falls, the access is a write to the captured address.
- R6: `dout_oe` is 0 whenever the synchronised output enable is high or the synchronised write enable is low, so a write takes priority over driving the bus.
- R7: While chip enable is high the block is in standby: `dout_oe` is 0 and a low write enable stores nothing.
- R8: After chip enable rises, the block ignores any chip-enable fall that is detected within `PRECHARGE` cycles. An ignored fall starts no access, and `dout_oe` stays 0 until a later accepted fall.
- R9: Read data becomes valid two clock cycles after the address capture. With output enable already low, `dout_oe` rises five clock edges after the chip-enable pin falls (two synchroniser stages, the capture edge and two cycles of latency), and not before.
- R10: Reset does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the interface |
| rst | input | 1 | Active-high synchronous reset of the control state |
| ce_n | input | 1 | Active-low chip enable. Its falling edge captures the address |
| oe_n | input | 1 | Active-low output enable, which gates only the output driver |
| we_n | input | 1 | Active-low write enable |
| addr_i | input | ADDR_W | Byte address, sampled at the accepted chip-enable fall |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data to the bus |
| dout_oe | output | 1 | High when the block drives `dout` onto the bus |

## Verification
The bench tries several patterns: plain reads of bytes written earlier, writes that begin after the capture, and writes whose write enable is already low at the chip-enable fall. Comparing these two write orders separates the two paths that start a write. Some accesses move the address pins in the middle of the access, and a read of both addresses shows which location the read or write actually used. A chip-enable fall placed inside the precharge window, standby cycles with write enable low, and a reset between a write and its read-back each check one thing: that an access really was refused, or that the stored bytes survived. One read samples `dout_oe` exactly one cycle before and at the expected latency.

// File: rtl/cel_pkg.sv
package cel_pkg;
  // synchronised strobes, active low as at the pins
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
  } cel_ctl_t;

  // cycles from address capture to valid read data
  localparam int RD_LAT = 2;
endpackage

// File: rtl/cel_sync.sv
module cel_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cel_ctrl.sv
module cel_ctrl
  import cel_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PRECHARGE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  cel_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              rd_valid,
  output logic              wr_en
);
  localparam int PW  = $clog2(PRECHARGE + 1);
  localparam int AGW = $clog2(RD_LAT + 1);

  logic           ce_q;
  logic [PW-1:0]  pc_cnt;
  logic [AGW-1:0] rd_age;
  logic           ce_fall, ce_rise, accept;

  assign ce_fall = ce_q & ~ctl.ce;
  assign ce_rise = ~ce_q & ctl.ce;
  assign accept  = ce_fall && (pc_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b1;
      active   <= 1'b0;
      pc_cnt   <= '0;
      rd_age   <= '0;
      lat_addr <= '0;
    end else begin
      ce_q <= ctl.ce;
      if (ce_rise)
        pc_cnt <= PW'(PRECHARGE);
      else if (pc_cnt != '0)
        pc_cnt <= pc_cnt - 1'b1;

      if (ctl.ce)
        active <= 1'b0;
      else if (accept)
        active <= 1'b1;

      if (accept) begin
        lat_addr <= addr_i;
        rd_age   <= '0;
      end else if (active && rd_age != AGW'(RD_LAT)) begin
        rd_age <= rd_age + 1'b1;
      end
    end
  end

  assign rd_valid = active && (rd_age == AGW'(RD_LAT));
  assign wr_en    = active && !ctl.we;

  // captured address holds for the whole access
  assert_addr_held_R3: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(lat_addr));

  // a high chip enable ends the access on the next edge
  assert_standby_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.ce |=> !active);

  // no access may start while precharge is running
  assert_precharge_block_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_cnt != '0 && !active) |=> !active);

  // read data never valid in the capture cycle or the one after
  assert_latency_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> !rd_valid);
  assert_latency_second_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |=> !rd_valid);
endmodule

// File: rtl/cel_array.sv
module cel_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cel_byte_mem.sv
module cel_byte_mem
  import cel_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PRECHARGE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  cel_ctl_t          ctl_s;
  logic [2:0]        ctl_raw, ctl_sync;
  logic              active, rd_valid, wr_en;
  logic [ADDR_W-1:0] lat_addr;

  assign ctl_raw = {ce_n, oe_n, we_n};
  assign ctl_s   = cel_ctl_t'(ctl_sync);

  cel_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_sync)
  );

  cel_ctrl #(.ADDR_W(ADDR_W), .PRECHARGE(PRECHARGE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl_s),
    .addr_i   (addr_i),
    .active   (active),
    .lat_addr (lat_addr),
    .rd_valid (rd_valid),
    .wr_en    (wr_en)
  );

  cel_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (lat_addr),
    .wdata (din),
    .rdata (dout)
  );

  assign dout_oe = rd_valid && !ctl_s.oe && ctl_s.we;

  // the bus is only driven inside an access
  assert_drive_in_access_R2: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> active);
endmodule

// File: tb/test_cel_byte_mem.sv
module test_cel_byte_mem;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int PRE = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  event          smp_ev;
  bit            mon_done;

  always #4 clk = ~clk;

  cel_byte_mem #(.ADDR_W(AW), .DATA_W(DW), .PRECHARGE(PRE)) i_cel_byte_mem (
    .clk (clk), .rst (rst), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .addr_i (addr_i), .din (din), .dout (dout), .dout_oe (dout_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares the bus against queued expectations
  initial begin
    forever begin
      @(smp_ev);
      mon_done = 1'b0;
      if (exp_q.size() != 0) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout_oe == 1'b1, t, dout_oe, 1);
        chk(dout == e, t, dout, e);
      end
      mon_done = 1'b1;
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e,
                    input string req, input bit move_addr);
    addr_i = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    idle(4);
    if (move_addr) addr_i = a ^ 11'h155;  // R3: pins move after capture
    idle(4);
    exp_q.push_back(e); tag_q.push_back(req);
    -> smp_ev;
    #1;
    ce_n = 1'b1; oe_n = 1'b1;
    idle(PRE + 6);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [AW-1:0] live, input bit early);
    addr_i = a; din = d; oe_n = 1'b0;
    we_n = early ? 1'b0 : 1'b1;
    ce_n = 1'b0;
    idle(4);
    addr_i = live;
    we_n = 1'b0;
    idle(4);
    chk(dout_oe == 1'b0, "R6 write priority", dout_oe, 0);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    idle(PRE + 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk(dout_oe == 1'b0, "R1 reset", dout_oe, 0);

    // plain writes and reads back (R4, R2)
    wr(11'h010, 8'hA5, 11'h010, 1'b0);
    wr(11'h7FF, 8'h3C, 11'h7FF, 1'b0);
    wr(11'h000, 8'h01, 11'h000, 1'b0);
    rd(11'h010, 8'hA5, "R2 read 010", 1'b0);
    rd(11'h7FF, 8'h3C, "R2 read 7FF", 1'b0);
    rd(11'h000, 8'h01, "R2 read 000", 1'b0);

    // R3: moving pins during a read
    rd(11'h010, 8'hA5, "R3 read ignores pins", 1'b1);

    // R4: write to captured address while live pins point elsewhere
    wr(11'h020, 8'h77, 11'h7FF, 1'b0);
    rd(11'h020, 8'h77, "R4 captured addr written", 1'b0);
    rd(11'h7FF, 8'h3C, "R4 live addr untouched", 1'b0);

    // R5: write enable low before chip enable falls
    wr(11'h055, 8'hC3, 11'h055, 1'b1);
    rd(11'h055, 8'hC3, "R5 early write", 1'b0);

    // R6: output enable high releases the bus during a read
    addr_i = 11'h010; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    idle(8);
    chk(dout_oe == 1'b0, "R6 oe high", dout_oe, 0);
    oe_n = 1'b0;
    idle(3);
    chk(dout_oe == 1'b1, "R6 oe low again", dout_oe, 1);

    // R8: fall inside precharge window ignored
    ce_n = 1'b1;
    idle(1);
    ce_n = 1'b0;
    idle(12);
    chk(dout_oe == 1'b0, "R8 precharge ignore", dout_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(PRE + 6);

    // R7: standby with write enable low stores nothing
    addr_i = 11'h010; din = 8'hEE; we_n = 1'b0; oe_n = 1'b0;
    idle(8);
    chk(dout_oe == 1'b0, "R7 standby quiet", dout_oe, 0);
    we_n = 1'b1; oe_n = 1'b1;
    idle(4);
    rd(11'h010, 8'hA5, "R7 standby no write", 1'b0);

    // R9: exact latency with oe already low
    oe_n = 1'b0; we_n = 1'b1; addr_i = 11'h020;
    idle(3);
    ce_n = 1'b0;
    idle(4);
    chk(dout_oe == 1'b0, "R9 not yet valid", dout_oe, 0);
    idle(1);
    chk(dout_oe == 1'b1, "R9 valid at latency", dout_oe, 1);
    chk(dout == 8'h77, "R9 data", dout, 8'h77);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(PRE + 6);

    // R10: reset keeps contents
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    chk(dout_oe == 1'b0, "R1 reset again", dout_oe, 0);
    rd(11'h055, 8'hC3, "R10 contents kept", 1'b0);

    idle(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule